// File: doc/BRIEF.md
# Pipelined ADC Digital Error Correction

This block is the digital back end of an eleven-stage pipelined analog-to-digital converter. Every stage resolves a 2-bit coarse decision for each sample. The decisions for one sample arrive staggered, each stage one half convert period after the stage in front of it. The block runs on a single internal clock at twice the convert rate. It delays each stage's decision by a stage-specific number of sub-clock cycles, so that all eleven decisions for one sample meet in the same cycle. It then merges them by overlapping addition into a 12-bit word and clamps that word at full scale. The output carries straight offset binary, or two's complement when the top bit is flipped, and an enable that a pad cell turns into high impedance.

The stream runs in one direction only and cannot be stalled. There is no ready input. A word sits on `data_o` for two sub-clock cycles, and `out_valid_o` is high during the first of them, so a consumer must take it then. An internal phase flag starts at reset. A new sample enters on the first sub-clock edge after reset and on every second edge after that.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Stage k (k = 1 to 11) presents its 2-bit code on `stage_code_i[2k-1:2k-2]`. Its code for a sample is valid in the sub-clock cycle that lies k-1 cycles after the cycle carrying stage 1's code for that same sample. Values in any other cycle have no effect on any output word.
- R2: After reset is released, stage 1's code is captured for a new sample on sub-clock edges 1, 3, 5 and so on, counting the first edge with reset high as edge 1.
- R3: The corrected word equals code(1)·1024 plus the sum, over k = 2 to 11, of code(k)·2^(11-k). Each pair of neighbouring stages therefore overlaps by one bit.
- R4: When that sum exceeds 4095, the word is 4095 (all ones) and never wraps. A sum of exactly 4095 passes through unchanged.
- R5: The word for a sample whose stage-1 code is captured on edge N appears after edge N+12, which is 13 sub-clock edges or 6.5 convert cycles. `out_valid_o` is high for exactly that one cycle.
- R6: `out_valid_o` is low during reset and stays low until the first sample's word appears. It is never high in two consecutive cycles, and `data_o` reads as a zero word during this time.
- R7: `data_o` keeps the same word for the cycle after the valid cycle.
- R8: With `msb_inv_i` low the output is offset binary, so a sum of 2048 reads 100000000000. With `msb_inv_i` high, only bit 11 is inverted. The control acts combinationally on the output.
- R9: With `hiz_i` high, `data_en_o` is low and `data_o` is all zeros. With `hiz_i` low, `data_en_o` is high. Raising `hiz_i` does not disturb the pipeline, so later words come out correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sub-clock at twice the convert rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_code_i | input | 22 | Eleven 2-bit stage decisions; stage k at bits [2k-1:2k-2] |
| msb_inv_i | input | 1 | High inverts the output MSB (two's complement) |
| hiz_i | input | 1 | High releases the output bus (enable low, data zero) |
| data_o | output | 12 | Corrected, formatted result |
| data_en_o | output | 1 | Output drive enable for the pad cell |
| out_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
Clamping and MSB inversion can act on the same word: a sample whose overlap sum passes 4095 is clamped and then has its top bit flipped, so it must read 011111111111. The bench provokes this by replaying a set of boundary samples (zero, exactly 4095, 4096, the largest possible sum, and mid-scale) once with `msb_inv_i` low and once with it high. It compares every word against its own overlap-sum model. The stage inputs carry filler codes in the off-phase cycles, so any misalignment shows up as a wrong word. A high-impedance window is also placed across several valid strobes, and the words that follow it are checked.

// File: rtl/pipe_adc_pkg.sv
package pipe_adc_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] stage_code_t;
endpackage

// File: rtl/ec_delay.sv
module ec_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/ec_overlap_add.sv
module ec_overlap_add #(
  parameter int NSTAGE = 11,
  localparam int RES_W = NSTAGE + 1,
  localparam int SUM_W = RES_W + 1
) (
  input  logic [2*NSTAGE-1:0] codes_i,
  output logic [RES_W-1:0]    word_o
);
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NSTAGE; k++) begin
      sum = sum + (SUM_W'(codes_i[2*k +: 2]) << (NSTAGE - 1 - k));
    end
    word_o = sum[SUM_W-1] ? '1 : sum[RES_W-1:0];
  end
endmodule

// File: rtl/ec_out_stage.sv
module ec_out_stage #(
  parameter int RES_W = 12,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [RES_W-1:0] word_i,
  input  logic             msb_inv_i,
  input  logic             hiz_i,
  output logic [RES_W-1:0] data_o,
  output logic             data_en_o,
  output logic             vld_o
);
  logic [RES_W-1:0] word_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [RES_W-1:0] last_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int j = 0; j < DEPTH; j++) word_q[j] <= '0;
    end else begin
      vld_q[0] <= vld_i;
      if (vld_i) word_q[0] <= word_i;
      for (int j = 1; j < DEPTH; j++) begin
        vld_q[j] <= vld_q[j-1];
        if (vld_q[j-1]) word_q[j] <= word_q[j-1];
      end
    end
  end

  assign last_word = word_q[DEPTH-1];
  assign vld_o     = vld_q[DEPTH-1];
  assign data_en_o = ~hiz_i;
  assign data_o    = hiz_i ? '0 : {last_word[RES_W-1] ^ msb_inv_i, last_word[RES_W-2:0]};

  AST_VALID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R6

  AST_HOLD_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> $stable(last_word)); // R7
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import pipe_adc_pkg::*;
#(
  parameter int NSTAGE   = 11,
  parameter int LAT_HALF = 13,
  localparam int RES_W      = NSTAGE + 1,
  localparam int OUT_STAGES = LAT_HALF - NSTAGE,
  localparam int IN_W       = CODE_W * NSTAGE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  stage_code_i,
  input  logic             msb_inv_i,
  input  logic             hiz_i,
  output logic [RES_W-1:0] data_o,
  output logic             data_en_o,
  output logic             out_valid_o
);
  logic             phase_q;
  logic [IN_W-1:0]  aligned;
  logic             aligned_vld;
  logic [RES_W-1:0] corr_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  // Later stages wait fewer sub-clock cycles; stage k waits NSTAGE-k+1 edges.
  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    ec_delay #(.W(CODE_W), .DEPTH(NSTAGE - k)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (stage_code_i[CODE_W*k +: CODE_W]),
      .q_o    (aligned[CODE_W*k +: CODE_W])
    );
  end

  ec_delay #(.W(1), .DEPTH(NSTAGE)) u_vld_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (~phase_q),
    .q_o    (aligned_vld)
  );

  ec_overlap_add #(.NSTAGE(NSTAGE)) u_add (
    .codes_i (aligned),
    .word_o  (corr_word)
  );

  ec_out_stage #(.RES_W(RES_W), .DEPTH(OUT_STAGES)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (aligned_vld),
    .word_i    (corr_word),
    .msb_inv_i (msb_inv_i),
    .hiz_i     (hiz_i),
    .data_o    (data_o),
    .data_en_o (data_en_o),
    .vld_o     (out_valid_o)
  );

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_vld |-> (corr_word >= {aligned[CODE_W-1:0], {(RES_W-CODE_W){1'b0}}})); // R4

  AST_ALIGN_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_vld |=> !aligned_vld); // R2
endmodule

// File: tb/pipe_adc_corrector_bench.sv
module pipe_adc_corrector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NST  = 11;
  localparam int RW   = 12;
  localparam int MAXS = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*NST-1:0] codes = '0;
  logic            inv = 1'b0;
  logic            hiz = 1'b0;
  logic [RW-1:0]   data;
  logic            en;
  logic            vld;

  int    n_chk = 0;
  int    n_fail = 0;
  int    edge_cnt = 0;
  int    nsmp = 0;
  int    hz_lo = 0;
  int    hz_hi = 0;
  bit    chk_on = 1'b0;
  string tag = "R3";
  logic [1:0] tab [MAXS][NST];

  pipe_adc_corrector u_pipe_adc_corrector (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .stage_code_i (codes),
    .msb_inv_i    (inv),
    .hiz_i        (hiz),
    .data_o       (data),
    .data_en_o    (en),
    .out_valid_o  (vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) edge_cnt <= rst_n ? edge_cnt + 1 : 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(int n, int k);
    if (n >= 0 && n < nsmp) return tab[n][k-1];
    return 2'b11;
  endfunction

  function automatic logic [RW-1:0] ref_word(int n);
    int s = 0;
    for (int k = 1; k <= NST; k++) s += int'(code_of(n, k)) << (NST - k);
    if (s > 4095) s = 4095;
    return RW'(s);
  endfunction

  function automatic logic [RW-1:0] fmt(logic [RW-1:0] w);
    return {w[RW-1] ^ inv, w[RW-2:0]};
  endfunction

  // Check what the last edge produced, then drive the inputs for the next edge.
  always @(negedge clk) begin
    int e;
    int ne;
    bit exp_v;
    logic [RW-1:0] exp_w;
    e = edge_cnt;
    if (chk_on) begin
      exp_v = (e >= 13) && ((e - 13) % 2 == 0);
      exp_w = (e >= 13) ? fmt(ref_word((e - 13) / 2)) : fmt('0);
      chk(vld == exp_v, (e < 13) ? "R6" : "R5", "out_valid", int'(vld), int'(exp_v));
      if (hiz) begin
        chk(!en && data == '0, "R9", "released bus", int'({en, data}), 0);
      end else begin
        chk(en == 1'b1, "R9", "drive enable", int'(en), 1);
        chk(data == exp_w, (e >= 13 && !exp_v) ? "R7" : tag, "data", int'(data), int'(exp_w));
      end
    end
    ne = e + 1;
    hiz = (ne >= hz_lo) && (ne < hz_hi);
    for (int k = 1; k <= NST; k++) begin
      int d;
      d = ne - k;
      if (d >= 0 && d % 2 == 0) codes[2*(k-1) +: 2] = code_of(d / 2, k);
      else                      codes[2*(k-1) +: 2] = 2'b11;
    end
  end

  task automatic run_case(int n, int lo, int hi, bit inv_v, string t);
    @(negedge clk);
    chk_on = 1'b0;
    rst_n  = 1'b0;
    nsmp = n; hz_lo = lo; hz_hi = hi; inv = inv_v; tag = t;
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    chk_on = 1'b1;
    repeat (2*n + 16) @(negedge clk);
  endtask

  task automatic load_bounds();
    for (int s = 0; s < 5; s++)
      for (int k = 0; k < NST; k++) tab[s][k] = 2'b00;
    for (int k = 1; k < NST; k++) tab[1][k] = 2'b01;
    tab[1][0] = 2'b11;                          // exactly 4095
    tab[2][0] = 2'b11; tab[2][1] = 2'b10;       // 4096, clamps
    for (int k = 0; k < NST; k++) tab[3][k] = 2'b11; // 6141, clamps
    tab[4][0] = 2'b10;                          // 2048, mid-scale
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk_on = 1'b0; rst_n = 1'b0; inv = 1'b0; hz_lo = 0; hz_hi = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(vld == 1'b0, "R6", "valid in reset", int'(vld), 0);
    chk(en == 1'b1, "R9", "enable in reset", int'(en), 1);
    chk(data == '0, "R6", "data in reset", int'(data), 0);
  endtask

  task automatic t_mixed();
    // R1 R2: off-phase cycles carry filler codes that must never reach a word
    for (int s = 0; s < 12; s++)
      for (int k = 0; k < NST; k++) tab[s][k] = 2'((s*5 + k*3 + (s ^ k)) % 4);
    run_case(12, 0, 0, 1'b0, "R1 R2 R3");
  endtask

  task automatic t_bounds();
    load_bounds();
    run_case(5, 0, 0, 1'b0, "R4");
  endtask

  task automatic t_inverted();
    load_bounds();
    run_case(5, 0, 0, 1'b1, "R8");
  endtask

  task automatic t_release();
    for (int s = 0; s < 10; s++)
      for (int k = 0; k < NST; k++) tab[s][k] = 2'((s + k) % 4);
    run_case(10, 16, 22, 1'b0, "R9");
  endtask

  initial begin
    t_reset_state();
    t_mixed();
    t_bounds();
    t_inverted();
    t_release();
    chk_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule